// File: doc/BRIEF.md
# Serial Three-Wire Configuration Latch Loader

This block receives configuration words over a three-wire serial link (serial clock, serial data and a load strobe) and distributes them into four parallel holding latches. Every rising edge of the serial clock moves one data bit into a 24-bit shift register, with the most significant bit sent first. When the load strobe rises, the upper 22 bits of the register are copied into one of four latches. The latch is chosen by the two lowest bits of the same word, so no separate address phase is needed.

The three serial lines come from off-chip and run asynchronously to the system clock. Each line passes through a two-stage synchronizer, and edges are detected in the system clock domain. Whenever a latch is written, the block raises a one-cycle update pulse together with the 2-bit code of the latch that changed. Downstream logic can use the pulse to act on a new setting.

Top module: `tw_latch_loader`

## Requirements
- R1: While reset is asserted and after it is released, all four latch outputs read zero and the update pulse is low, until the first load.
- R2: Each synchronized rising edge of the serial clock shifts the synchronized data bit into the least significant end of the 24-bit register, so words arrive MSB first. If more than 24 bits are sent before a load, only the last 24 bits count.
- R3: A load happens once for each rising edge of the load strobe. Serial clock edges while the strobe stays high cause no further load.
- R4: At a load, word bits [23:2] are written into the latch selected by word bits [1:0]. Code 0 selects the reference latch, 1 the N-counter latch, 2 the function latch and 3 the initialization latch. The control bits themselves are not stored.
- R5: A load leaves the three latches it does not address unchanged.
- R6: Each load produces an update pulse exactly one system clock wide. The pulse carries the 2-bit selection code, and the chosen latch shows its new value in the same cycle as the pulse.
- R7: Falling serial clock edges, and data changes while the serial clock is low, do not affect the shifted word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ser_clk | input | 1 | Serial clock, asynchronous to clk |
| ser_data | input | 1 | Serial data, MSB first |
| ser_le | input | 1 | Load strobe; a rising edge transfers the word |
| lat_ref | output | 22 | Reference latch contents (code 0) |
| lat_ncnt | output | 22 | N-counter latch contents (code 1) |
| lat_func | output | 22 | Function latch contents (code 2) |
| lat_init | output | 22 | Initialization latch contents (code 3) |
| upd_valid | output | 1 | One-cycle pulse marking a latch update |
| upd_addr | output | 2 | Code of the latch updated with the pulse |

## Verification
The assertions assume that every serial line level lasts long enough for the synchronizers to capture it. They also assume that data is stable across each rising serial clock edge, so the synchronized data bit at a detected edge is the intended bit. The bench keeps every level for at least three system clocks and changes data only while the serial clock is low. It does inject short data glitches during those low phases. It also keeps the load strobe low for several clocks between loads, so each strobe rise is a separate, clean edge.

// File: rtl/tw_ld_pkg.sv
package tw_ld_pkg;
  parameter int WORD_W = 24;
  parameter int CTRL_W = 2;
  parameter int NUM_LAT = 4;
  localparam int PAY_W = WORD_W - CTRL_W;

  typedef enum logic [CTRL_W-1:0] {
    SEL_REF  = 2'd0,
    SEL_NCNT = 2'd1,
    SEL_FUNC = 2'd2,
    SEL_INIT = 2'd3
  } sel_e;

  function automatic logic [PAY_W-1:0] payload_of(input logic [WORD_W-1:0] w);
    return w[WORD_W-1:CTRL_W];
  endfunction

  function automatic logic [CTRL_W-1:0] sel_of(input logic [WORD_W-1:0] w);
    return w[CTRL_W-1:0];
  endfunction

  function automatic logic [WORD_W-1:0] shift_in(input logic [WORD_W-1:0] w, input logic b);
    return {w[WORD_W-2:0], b};
  endfunction
endpackage

// File: rtl/tw_sync.sv
module tw_sync #(
  parameter int N = 3,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] async_in,
  output logic [N-1:0] lvl,
  output logic [N-1:0] rise
);
  logic [N-1:0] stg [STAGES];
  logic [N-1:0] prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) stg[i] <= '0;
      prev <= '0;
    end else begin
      stg[0] <= async_in;
      for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
      prev <= stg[STAGES-1];
    end
  end

  assign lvl  = stg[STAGES-1];
  assign rise = stg[STAGES-1] & ~prev;
endmodule

// File: rtl/tw_shifter.sv
module tw_shifter
  import tw_ld_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              shift_en,
  input  logic              bit_in,
  output logic [WORD_W-1:0] word_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        word_q <= '0;
    else if (shift_en) word_q <= shift_in(word_q, bit_in);
  end
endmodule

// File: rtl/tw_latch_bank.sv
module tw_latch_bank
  import tw_ld_pkg::*;
(
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           load,
  input  logic [WORD_W-1:0]              word,
  output logic [NUM_LAT-1:0][PAY_W-1:0]  lat_q,
  output logic                           valid_q,
  output logic [CTRL_W-1:0]              addr_q
);
  logic [CTRL_W-1:0] sel;
  logic [PAY_W-1:0]  pay;

  assign sel = sel_of(word);
  assign pay = payload_of(word);

  for (genvar g = 0; g < NUM_LAT; g++) begin : g_lat
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                 lat_q[g] <= '0;
      else if (load && sel == CTRL_W'(g))         lat_q[g] <= pay;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      addr_q  <= '0;
    end else begin
      valid_q <= load;
      if (load) addr_q <= sel;
    end
  end
endmodule

// File: rtl/tw_latch_loader.sv
module tw_latch_loader
  import tw_ld_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ser_clk,
  input  logic             ser_data,
  input  logic             ser_le,
  output logic [PAY_W-1:0] lat_ref,
  output logic [PAY_W-1:0] lat_ncnt,
  output logic [PAY_W-1:0] lat_func,
  output logic [PAY_W-1:0] lat_init,
  output logic             upd_valid,
  output logic [1:0]       upd_addr
);
  localparam int IDX_CLK = 0;
  localparam int IDX_DAT = 1;
  localparam int IDX_LE  = 2;

  logic [2:0] s_lvl, s_rise;
  logic sclk_rise, le_rise, din_s;
  logic [WORD_W-1:0] shift_word;
  logic [NUM_LAT-1:0][PAY_W-1:0] bank;

  tw_sync #(.N(3), .STAGES(2)) u_sync (
    .clk(clk), .rst_n(rst_n),
    .async_in({ser_le, ser_data, ser_clk}),
    .lvl(s_lvl), .rise(s_rise)
  );

  assign sclk_rise = s_rise[IDX_CLK];
  assign le_rise   = s_rise[IDX_LE];
  assign din_s     = s_lvl[IDX_DAT];

  tw_shifter u_shift (
    .clk(clk), .rst_n(rst_n),
    .shift_en(sclk_rise), .bit_in(din_s), .word_q(shift_word)
  );

  tw_latch_bank u_bank (
    .clk(clk), .rst_n(rst_n),
    .load(le_rise), .word(shift_word),
    .lat_q(bank), .valid_q(upd_valid), .addr_q(upd_addr)
  );

  assign lat_ref  = bank[SEL_REF];
  assign lat_ncnt = bank[SEL_NCNT];
  assign lat_func = bank[SEL_FUNC];
  assign lat_init = bank[SEL_INIT];
endmodule

// File: rtl/tw_latch_loader_chk.sv
module tw_latch_loader_chk
  import tw_ld_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              sclk_rise,
  input logic              le_rise,
  input logic              din_s,
  input logic [WORD_W-1:0] shift_word,
  input logic [PAY_W-1:0]  lat_ref,
  input logic [PAY_W-1:0]  lat_ncnt,
  input logic [PAY_W-1:0]  lat_func,
  input logic [PAY_W-1:0]  lat_init,
  input logic              upd_valid,
  input logic [1:0]        upd_addr
);
  p_shift_r2: assert property (@(posedge clk) disable iff (!rst_n)
    sclk_rise |=> shift_word == {$past(shift_word[WORD_W-2:0]), $past(din_s)});

  p_no_shift_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !sclk_rise |=> $stable(shift_word));

  p_edge_load_r3: assert property (@(posedge clk) disable iff (!rst_n)
    le_rise |=> upd_valid);

  p_no_load_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !le_rise |=> !upd_valid);

  p_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
    upd_valid |=> !upd_valid);

  p_addr_r6: assert property (@(posedge clk) disable iff (!rst_n)
    upd_valid |-> upd_addr == $past(shift_word[1:0]));

  p_ref_value_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_valid && upd_addr == SEL_REF) |-> lat_ref == $past(shift_word[WORD_W-1:2]));

  p_init_value_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_valid && upd_addr == SEL_INIT) |-> lat_init == $past(shift_word[WORD_W-1:2]));

  p_ref_keep_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !(upd_valid && upd_addr == SEL_REF) |-> $stable(lat_ref));

  p_ncnt_keep_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !(upd_valid && upd_addr == SEL_NCNT) |-> $stable(lat_ncnt));

  p_func_keep_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !(upd_valid && upd_addr == SEL_FUNC) |-> $stable(lat_func));

  p_init_keep_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !(upd_valid && upd_addr == SEL_INIT) |-> $stable(lat_init));
endmodule

bind tw_latch_loader tw_latch_loader_chk u_chk (
  .clk(clk), .rst_n(rst_n),
  .sclk_rise(sclk_rise), .le_rise(le_rise), .din_s(din_s),
  .shift_word(shift_word),
  .lat_ref(lat_ref), .lat_ncnt(lat_ncnt), .lat_func(lat_func), .lat_init(lat_init),
  .upd_valid(upd_valid), .upd_addr(upd_addr)
);

// File: tb/tb_tw_latch_loader.sv
module tb_tw_latch_loader;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ser_clk = 1'b0, ser_data = 1'b0, ser_le = 1'b0;
  logic [21:0] lat_ref, lat_ncnt, lat_func, lat_init;
  logic upd_valid;
  logic [1:0] upd_addr;

  int checks = 0;
  int errors = 0;
  int loads_sent = 0;
  int updates_seen = 0;
  logic [21:0] model [4];
  logic [23:0] exp_q [$];
  logic prev_valid = 1'b0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  tw_latch_loader dut (
    .clk(clk), .rst_n(rst_n), .ser_clk(ser_clk), .ser_data(ser_data), .ser_le(ser_le),
    .lat_ref(lat_ref), .lat_ncnt(lat_ncnt), .lat_func(lat_func), .lat_init(lat_init),
    .upd_valid(upd_valid), .upd_addr(upd_addr)
  );

  function automatic logic [21:0] lat_out(input int idx);
    case (idx)
      0: return lat_ref;
      1: return lat_ncnt;
      2: return lat_func;
      default: return lat_init;
    endcase
  endfunction

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, expv);
    end
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic shift_bits(input logic [63:0] v, input int n, input bit glitch);
    for (int i = n - 1; i >= 0; i--) begin
      ser_data = v[i];
      wait_n(3);
      ser_clk = 1'b1;
      wait_n(3);
      ser_clk = 1'b0;
      if (glitch) begin
        wait_n(1);
        ser_data = ~v[i];
        wait_n(3);
        ser_data = v[i];
      end
      wait_n(3);
    end
  endtask

  task automatic pulse_le(input logic [23:0] expected_word, input int extra_bits);
    exp_q.push_back(expected_word);
    loads_sent++;
    ser_le = 1'b1;
    wait_n(4);
    if (extra_bits > 0) shift_bits(64'h5A5A_A5A5_3C3C_C3C3, extra_bits, 1'b0);
    ser_le = 1'b0;
    wait_n(6);
  endtask

  task automatic send_word(input logic [23:0] w);
    shift_bits({40'd0, w}, 24, 1'b0);
    pulse_le(w, 0);
  endtask

  // Monitor / scoreboard
  always @(negedge clk) begin
    if (rst_n && !done) begin
      if (prev_valid && upd_valid)
        check(1'b0, "R6 pulse wider than one cycle", 32'(upd_valid), 32'h0);
      if (upd_valid) begin
        updates_seen++;
        if (exp_q.size() == 0) begin
          check(1'b0, "R3 unexpected load", 32'(upd_addr), 32'hFFFF_FFFF);
        end else begin
          logic [23:0] w;
          int sel;
          w = exp_q.pop_front();
          sel = int'(w[1:0]);
          check(upd_addr == w[1:0], "R6 update code", 32'(upd_addr), 32'(w[1:0]));
          check(lat_out(sel) == w[23:2], "R4 latch value", 32'(lat_out(sel)), 32'(w[23:2]));
          for (int k = 0; k < 4; k++)
            if (k != sel)
              check(lat_out(k) == model[k], "R5 unaddressed latch", 32'(lat_out(k)), 32'(model[k]));
          model[sel] = w[23:2];
        end
      end
      prev_valid = upd_valid;
    end
  end

  initial begin
    for (int k = 0; k < 4; k++) model[k] = '0;
    wait_n(5);
    // R1: state during reset
    for (int k = 0; k < 4; k++) check(lat_out(k) == 22'd0, "R1 latch in reset", 32'(lat_out(k)), 32'h0);
    check(upd_valid == 1'b0, "R1 valid in reset", 32'(upd_valid), 32'h0);
    rst_n = 1'b1;
    wait_n(5);
    for (int k = 0; k < 4; k++) check(lat_out(k) == 22'd0, "R1 latch after reset", 32'(lat_out(k)), 32'h0);
    check(upd_valid == 1'b0, "R1 valid after reset", 32'(upd_valid), 32'h0);

    // R4 R5 R6: one word to each code
    send_word({22'h2AB_CDE, 2'd0});
    send_word({22'h155_432, 2'd1});
    send_word({22'h3FF_FFF, 2'd2});
    send_word({22'h000_001, 2'd3});
    // overwrite one latch, others must hold (R5)
    send_word({22'h1234_5, 2'd1});
    send_word({22'h0F0_F0F, 2'd2});

    // R7: data glitches while serial clock low do not disturb the word
    shift_bits({40'd0, 22'h2C3_A59, 2'd3}, 24, 1'b1);
    pulse_le({22'h2C3_A59, 2'd3}, 0);

    // R2: 30 bits sent, only the final 24 count
    shift_bits({34'd0, 6'b101101, 22'h19E_377, 2'd0}, 30, 1'b0);
    pulse_le({22'h19E_377, 2'd0}, 0);

    // R3: serial clocking while strobe held high gives no second load
    shift_bits({40'd0, 22'h3A0_5C1, 2'd2}, 24, 1'b0);
    pulse_le({22'h3A0_5C1, 2'd2}, 8);

    wait_n(20);
    check(exp_q.size() == 0, "R3 missing load", 32'(exp_q.size()), 32'h0);
    check(updates_seen == loads_sent, "R3 load count", 32'(updates_seen), 32'(loads_sent));
    for (int k = 0; k < 4; k++)
      check(lat_out(k) == model[k], "R5 final latch state", 32'(lat_out(k)), 32'(model[k]));
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=hung expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule